// File: doc/BRIEF.md
# Handshaked Command/Response Byte Engine

This block is the device half of a byte-serial command link. The host moves one byte at a time through a shift register that both sides share. The host paces each byte with an active-low request line. The engine answers on an active-low acknowledge line. In its first phase the engine collects a command code and then its arguments. When the argument count is reached it pulses a dispatch strobe, and the command, the count and the stored arguments are held steady for an external dispatcher. It then plays the response back one byte per handshake.

The engine looks up two lengths for each command code in a small built-in table: how many argument bytes to expect and how many response bytes to send. Either entry can be marked variable. A variable argument length is carried in-band as the first byte after the command. A variable response length is sent as the first response byte. The dispatcher reports whether it recognised the command. An unrecognised command gets a reply of zero bytes, sized from the table. Every byte the engine accepts or sends raises a single-cycle completion pulse, which the shift-register logic turns into its interrupt.

Top module: `hsb_cmd_engine`

## Requirements
- R1: After reset `ack_n` is high, `byte_done` and `disp_valid` are low, and the engine is idle, so the first accepted byte is taken as a command code.
- R2: A fall of `req_n` while `ack_n` is high drives `ack_n` low at the next clock edge. A rise of `req_n` while `ack_n` is low drives `ack_n` high at the next clock edge. Nothing changes while `req_n` is unchanged.
- R3: Each accepted or sent byte produces `byte_done` high for exactly one cycle, at the same edge where `ack_n` falls.
- R4: The length table holds these entries (args / response): 0x10 = 1/0, 0x20 = variable/variable, 0x30 = 4/0, 0x38 = 0/4, 0x78 = 0/variable, 0x7F = 0/2. Every other code is 0/0.
- R5: For a variable argument length, the byte after the command is the argument count. That byte is not stored as an argument.
- R6: When the received argument count equals the argument length, `disp_valid` pulses for one cycle. At that point `cmd_code`, `arg_count` and `args_flat` hold the command, the count and the arguments. Argument i sits in bits [8i+7:8i].
- R7: Arguments past ARG_CAP (default 8) are discarded but still counted, so dispatch still happens. The slots already stored keep the first ARG_CAP bytes.
- R8: With a fixed response length, the response bytes are `rsp_byte` at `rsp_idx` = 0, 1, ..., and each one appears on `rsp_out` at its handshake. After the last byte the engine is idle again.
- R9: With a variable response length, the first response byte is the size reported by the dispatcher. That many data bytes follow.
- R10: If `disp_known` is low, the response is zero bytes of the table length. If the table length is variable, the response is a single size byte of 0.
- R11: A byte with the wrong direction is dropped: the direction is device-to-host in idle or argument phase, or host-to-device in response phase. `ack_n` still handshakes, but there is no `byte_done` and the engine state does not change.
- R12: A command whose table response length is 0 returns the engine to idle straight after dispatch. A command with 0 arguments dispatches on its command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Host request, active low |
| host_wr | input | 1 | 1 = host-to-device byte, 0 = device-to-host |
| sr_in | input | 8 | Byte currently in the shift register from the host |
| ack_n | output | 1 | Device acknowledge, active low |
| byte_done | output | 1 | One-cycle pulse per accepted or sent byte |
| rsp_out | output | 8 | Response byte for the shift register |
| disp_valid | output | 1 | One-cycle pulse: command complete |
| cmd_code | output | 8 | Latched command code |
| arg_count | output | 8 | Argument bytes received (saturates at 255) |
| args_flat | output | 8*ARG_CAP | Stored argument bytes |
| disp_known | input | 1 | Dispatcher recognises `cmd_code` |
| disp_rsp_len | input | 8 | Response size from the dispatcher |
| rsp_idx | output | 8 | Index of the next response byte |
| rsp_byte | input | 8 | Dispatcher's response byte at `rsp_idx` |

## Verification
The hardest situations to reach are the overflow path and misdirected bytes. In the overflow case, a variable-length command announces more arguments than the buffer holds, and it must still dispatch while the stored slots stay frozen. A misdirected byte must complete the acknowledge handshake but leave the phase and response position alone. The bench reaches the overflow case by sending a length byte of 10 against an 8-slot buffer. It reaches the misdirected case by flipping the direction flag once in idle and once in the middle of a response. After each, it reads the remaining response to show that nothing moved.

// File: rtl/hsb_pkg.sv
// Package: shared types and the command length table for the byte engine.
// Assumes 8-bit command codes; table entries not listed default to 0/0.
package hsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARGS = 2'd1,
        ST_DISP = 2'd2,
        ST_RESP = 2'd3
    } eng_state_t;

    typedef struct packed {
        logic       arg_var;
        logic [7:0] arg_len;
        logic       rsp_var;
        logic [7:0] rsp_len;
    } len_entry_t;

    // Returns argument/response lengths for a command code.
    function automatic len_entry_t lookup_lengths(input logic [7:0] code);
        len_entry_t e;
        e = '{arg_var: 1'b0, arg_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd0};
        case (code)
            8'h10: e.arg_len = 8'd1;
            8'h20: begin e.arg_var = 1'b1; e.rsp_var = 1'b1; end
            8'h30: e.arg_len = 8'd4;
            8'h38: e.rsp_len = 8'd4;
            8'h78: e.rsp_var = 1'b1;
            8'h7F: e.rsp_len = 8'd2;
            default: ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/hsb_handshake.sv
// Module: request/acknowledge pacing for the byte link.
// Reacts only to a change of req_n; assumes req_n is already synchronous.
// Both lines are active low and idle high; req falling while ack is low
// is treated as invalid and ignored.
module hsb_handshake (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic ack_n,
    output logic new_byte,
    output logic ack_release
);
    logic req_q;
    logic req_changed;

    // Detect a change of the request line and classify it.
    always_comb begin
        req_changed = (req_n != req_q);
        new_byte    = req_changed && !req_n && ack_n;
        ack_release = req_changed &&  req_n && !ack_n;
    end

    // Track the last request level and drive acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b1;
            ack_n <= 1'b1;
        end else begin
            req_q <= req_n;
            if (new_byte)
                ack_n <= 1'b0;
            else if (ack_release)
                ack_n <= 1'b1;
        end
    end

    // R2: acknowledge is only held low while the seen request is low
    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !req_q);

    // R2: a falling acknowledge follows a request fall with ack high
    a_r2_ack_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> ($past(!req_n) && $past(ack_n)));

endmodule

// File: rtl/hsb_len_table.sv
// Module: combinational wrapper of the per-command length table.
// Assumes the code input is stable whenever the entry is consumed.
module hsb_len_table
    import hsb_pkg::*;
(
    input  logic [7:0] code,
    output len_entry_t entry
);
    // Look up the table entry for the current code.
    always_comb entry = lookup_lengths(code);
endmodule

// File: rtl/hsb_arg_store.sv
// Module: argument byte slots, one register per slot.
// Assumes the writer never issues wr_en with an index >= CAP.
module hsb_arg_store #(
    parameter int CAP = 8,
    localparam int IW = (CAP > 1) ? $clog2(CAP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [7:0]     wr_data,
    output logic [8*CAP-1:0] flat
);
    for (genvar g = 0; g < CAP; g++) begin : g_slot
        logic [7:0] slot_q;
        // Hold one argument byte; written when its index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= 8'h00;
            else if (wr_en && (wr_idx == IW'(g)))
                slot_q <= wr_data;
        end
        assign flat[8*g +: 8] = slot_q;
    end
endmodule

// File: rtl/hsb_cmd_engine.sv
// Module: command/response byte engine (top).
// Collects command, optional in-band length and arguments, strobes a
// dispatcher, then returns response bytes one handshake at a time.
// Assumes the dispatcher answers combinationally from cmd_code/args and
// rsp_idx, and that host inputs are synchronous to clk.
module hsb_cmd_engine
    import hsb_pkg::*;
#(
    parameter int ARG_CAP = 8,
    localparam int IW = (ARG_CAP > 1) ? $clog2(ARG_CAP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_n,
    input  logic                 host_wr,
    input  logic [7:0]           sr_in,
    output logic                 ack_n,
    output logic                 byte_done,
    output logic [7:0]           rsp_out,
    output logic                 disp_valid,
    output logic [7:0]           cmd_code,
    output logic [7:0]           arg_count,
    output logic [8*ARG_CAP-1:0] args_flat,
    input  logic                 disp_known,
    input  logic [7:0]           disp_rsp_len,
    output logic [7:0]           rsp_idx,
    input  logic [7:0]           rsp_byte
);
    eng_state_t state;
    len_entry_t tbl;
    logic       new_byte;
    logic       ack_release;
    logic       arg_var, rsp_var, rsp_known;
    logic [7:0] arg_len, rsp_len, rsp_sz, rsp_pos, rx_cnt;
    logic       store_en;
    logic [7:0] disp_size;
    logic       take_in, take_out;

    hsb_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_n       (req_n),
        .ack_n       (ack_n),
        .new_byte    (new_byte),
        .ack_release (ack_release)
    );

    hsb_len_table u_tbl (
        .code  (sr_in),
        .entry (tbl)
    );

    hsb_arg_store #(.CAP(ARG_CAP)) u_args (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (rx_cnt[IW-1:0]),
        .wr_data (sr_in),
        .flat    (args_flat)
    );

    // Qualify bytes by direction and derive store/size controls.
    always_comb begin
        take_in   = new_byte && host_wr;
        take_out  = new_byte && !host_wr;
        store_en  = (state == ST_ARGS) && take_in && !arg_var &&
                    (rx_cnt < 8'(ARG_CAP));
        disp_size = disp_known ? disp_rsp_len : (rsp_var ? 8'd0 : rsp_len);
    end

    // Phase sequencing, counters and response byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cmd_code   <= 8'h00;
            arg_var    <= 1'b0;
            arg_len    <= 8'd0;
            rsp_var    <= 1'b0;
            rsp_len    <= 8'd0;
            rsp_sz     <= 8'd0;
            rsp_pos    <= 8'd0;
            rsp_known  <= 1'b0;
            rx_cnt     <= 8'd0;
            rsp_out    <= 8'h00;
            byte_done  <= 1'b0;
            disp_valid <= 1'b0;
        end else begin
            byte_done  <= 1'b0;
            disp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (take_in) begin
                    cmd_code  <= sr_in;
                    arg_var   <= tbl.arg_var;
                    arg_len   <= tbl.arg_len;
                    rsp_var   <= tbl.rsp_var;
                    rsp_len   <= tbl.rsp_len;
                    rx_cnt    <= 8'd0;
                    rsp_pos   <= 8'd0;
                    byte_done <= 1'b1;
                    if (!tbl.arg_var && tbl.arg_len == 8'd0) begin
                        state      <= ST_DISP;
                        disp_valid <= 1'b1;
                    end else begin
                        state <= ST_ARGS;
                    end
                end
                ST_ARGS: if (take_in) begin
                    byte_done <= 1'b1;
                    if (arg_var) begin
                        arg_var <= 1'b0;
                        arg_len <= sr_in;
                        if (sr_in == 8'd0) begin
                            state      <= ST_DISP;
                            disp_valid <= 1'b1;
                        end
                    end else begin
                        if (rx_cnt != 8'hFF)
                            rx_cnt <= rx_cnt + 8'd1;
                        if ({1'b0, rx_cnt} + 9'd1 == {1'b0, arg_len}) begin
                            state      <= ST_DISP;
                            disp_valid <= 1'b1;
                        end
                    end
                end
                ST_DISP: begin
                    rsp_known <= disp_known;
                    rsp_sz    <= disp_size;
                    if (!rsp_var && rsp_len == 8'd0)
                        state <= ST_IDLE;
                    else
                        state <= ST_RESP;
                end
                ST_RESP: if (take_out) begin
                    byte_done <= 1'b1;
                    if (rsp_var) begin
                        rsp_out <= rsp_sz;
                        rsp_var <= 1'b0;
                        rsp_len <= rsp_sz;
                        if (rsp_sz == 8'd0)
                            state <= ST_IDLE;
                    end else begin
                        rsp_out <= (rsp_known && rsp_pos < rsp_sz) ? rsp_byte : 8'h00;
                        rsp_pos <= rsp_pos + 8'd1;
                        if ({1'b0, rsp_pos} + 9'd1 == {1'b0, rsp_len})
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign arg_count = rx_cnt;
    assign rsp_idx   = rsp_pos;

    // R3: completion pulse lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R3/R11: a completion pulse coincides with the acknowledge falling
    a_r3_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (!ack_n && $past(ack_n)));

    // R6: dispatch strobe lasts one cycle
    a_r6_disp_single: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);

    // R6: a dispatch strobe is followed by the dispatch phase
    a_r6_disp_phase: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (state == ST_DISP));

    // R8: fixed-length playback never runs past the response length
    a_r8_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP && !rsp_var) |-> (rsp_pos < rsp_len));

endmodule

// File: tb/hsb_cmd_engine_tb_top.sv
`timescale 1ns/100ps
module hsb_cmd_engine_tb_top;
    localparam int CAP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic host_wr = 1'b1;
    logic [7:0] sr_in = 8'h00;
    logic ack_n, byte_done, disp_valid;
    logic [7:0] rsp_out, cmd_code, arg_count, rsp_idx;
    logic [8*CAP-1:0] args_flat;
    logic disp_known;
    logic [7:0] disp_rsp_len, rsp_byte;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int disp_cnt = 0;
    logic [7:0] snap_cmd, snap_cnt;
    logic [8*CAP-1:0] snap_args;

    always #2.5 clk = ~clk;

    hsb_cmd_engine #(.ARG_CAP(CAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .host_wr(host_wr),
        .sr_in(sr_in), .ack_n(ack_n), .byte_done(byte_done),
        .rsp_out(rsp_out), .disp_valid(disp_valid), .cmd_code(cmd_code),
        .arg_count(arg_count), .args_flat(args_flat),
        .disp_known(disp_known), .disp_rsp_len(disp_rsp_len),
        .rsp_idx(rsp_idx), .rsp_byte(rsp_byte)
    );

    // Bench dispatcher model
    function automatic logic [7:0] exp_byte(input logic [7:0] c, input int i);
        return c + 8'(8'h11 * (i + 1));
    endfunction

    always_comb begin
        disp_known = (cmd_code == 8'h10) || (cmd_code == 8'h20) ||
                     (cmd_code == 8'h30) || (cmd_code == 8'h38) ||
                     (cmd_code == 8'h78);
        case (cmd_code)
            8'h38:   disp_rsp_len = 8'd4;
            8'h78:   disp_rsp_len = 8'd3;
            8'h20:   disp_rsp_len = 8'd2;
            default: disp_rsp_len = 8'd0;
        endcase
        rsp_byte = exp_byte(cmd_code, int'(rsp_idx));
    end

    // Monitors sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && byte_done) done_cnt++;
        if (rst_n && disp_valid) begin
            disp_cnt++;
            snap_cmd  = cmd_code;
            snap_cnt  = arg_count;
            snap_args = args_flat;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One full handshake; returns rsp_out sampled after ack falls
    task automatic xfer(input logic wr, input logic [7:0] d, output logic [7:0] got);
        int t;
        @(negedge clk);
        host_wr = wr; sr_in = d; req_n = 1'b0;
        t = 0;
        do begin @(negedge clk); t++; end while (ack_n !== 1'b0 && t < 50);
        got = rsp_out;
        req_n = 1'b1;
        t = 0;
        do begin @(negedge clk); t++; end while (ack_n !== 1'b1 && t < 50);
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        logic [7:0] g;
        xfer(1'b1, d, g);
    endtask

    task automatic recv(output logic [7:0] g);
        xfer(1'b0, 8'h00, g);
    endtask

    task automatic t_reset;
        check("R1 ack_n after reset", ack_n, 1);
        check("R1 byte_done after reset", byte_done, 0);
        check("R1 disp_valid after reset", disp_valid, 0);
    endtask

    task automatic t_handshake;
        int d0;
        d0 = done_cnt;
        @(negedge clk);
        host_wr = 1'b1; sr_in = 8'h10; req_n = 1'b0;
        @(negedge clk);
        check("R2 ack low one edge after req", ack_n, 0);
        check("R3 byte_done pulse", byte_done, 1);
        @(negedge clk);
        check("R3 byte_done single cycle", byte_done, 0);
        check("R2 ack held while req held", ack_n, 0);
        req_n = 1'b1;
        @(negedge clk);
        check("R2 ack high after release", ack_n, 1);
        check("R3 one pulse per byte", done_cnt - d0, 1);
        d0 = disp_cnt;
        send(8'h5A);
        check("R6 dispatch strobe", disp_cnt - d0, 1);
        check("R6 cmd_code", snap_cmd, 8'h10);
        check("R6 arg_count", snap_cnt, 1);
        check("R6 arg0", snap_args[7:0], 8'h5A);
    endtask

    task automatic t_fixed_rsp;
        logic [7:0] g;
        int d0;
        d0 = disp_cnt;
        send(8'h38);
        check("R12 zero-arg command dispatches", disp_cnt - d0, 1);
        for (int i = 0; i < 4; i++) begin
            recv(g);
            check($sformatf("R8 fixed response byte %0d", i), g, exp_byte(8'h38, i));
        end
        d0 = disp_cnt;
        send(8'h10); send(8'h22);
        check("R8 idle after last response byte", snap_cmd, 8'h10);
        check("R4 0x10 takes one argument", disp_cnt - d0, 1);
    endtask

    task automatic t_var_args;
        logic [7:0] g;
        int d0;
        d0 = disp_cnt;
        send(8'h20); send(8'd3);
        check("R5 length byte not dispatched", disp_cnt - d0, 0);
        send(8'h01); send(8'h02); send(8'h03);
        check("R5 dispatch after in-band count", disp_cnt - d0, 1);
        check("R5 arg_count", snap_cnt, 3);
        check("R5 args", snap_args[23:0], 24'h030201);
        recv(g);
        check("R9 size byte first", g, 2);
        recv(g); check("R9 data byte 0", g, exp_byte(8'h20, 0));
        recv(g); check("R9 data byte 1", g, exp_byte(8'h20, 1));
    endtask

    task automatic t_overflow;
        logic [7:0] g;
        int d0;
        d0 = disp_cnt;
        send(8'h20); send(8'd10);
        for (int i = 0; i < 10; i++) send(8'hA0 + 8'(i));
        check("R7 dispatch despite overflow", disp_cnt - d0, 1);
        check("R7 count includes discarded", snap_cnt, 10);
        check("R7 slot 0 kept", snap_args[7:0], 8'hA0);
        check("R7 last slot not overwritten", snap_args[8*CAP-1 -: 8], 8'hA0 + 8'(CAP-1));
        recv(g); check("R9 overflow size byte", g, 2);
        recv(g); recv(g);
    endtask

    task automatic t_unknown;
        logic [7:0] g;
        int d0;
        send(8'h7F);
        recv(g); check("R10 unknown byte 0 zero", g, 0);
        recv(g); check("R10 unknown byte 1 zero", g, 0);
        d0 = disp_cnt;
        send(8'h55);
        check("R10 default entry dispatches at once", disp_cnt - d0, 1);
        send(8'h78);
        check("R12 0x55 returned to idle", snap_cmd, 8'h78);
        recv(g); check("R9 variable size byte", g, 3);
        for (int i = 0; i < 3; i++) begin
            recv(g);
            check($sformatf("R9 variable data %0d", i), g, exp_byte(8'h78, i));
        end
    endtask

    task automatic t_wrong_dir;
        logic [7:0] g;
        int d0, dd;
        d0 = done_cnt;
        recv(g);
        check("R11 idle wrong-direction no byte_done", done_cnt - d0, 0);
        check("R11 ack released after drop", ack_n, 1);
        dd = disp_cnt;
        send(8'h38);
        check("R11 idle unchanged, command accepted", disp_cnt - dd, 1);
        recv(g); check("R11 resp byte 0", g, exp_byte(8'h38, 0));
        d0 = done_cnt;
        send(8'hEE);
        check("R11 resp wrong-direction no byte_done", done_cnt - d0, 0);
        for (int i = 1; i < 4; i++) begin
            recv(g);
            check($sformatf("R11 resp byte %0d unmoved", i), g, exp_byte(8'h38, i));
        end
    endtask

    task automatic t_zero_rsp;
        int d0;
        d0 = disp_cnt;
        send(8'h30);
        for (int i = 0; i < 4; i++) send(8'h40 + 8'(i));
        check("R4 0x30 takes four arguments", disp_cnt - d0, 1);
        check("R12 args of 0x30", snap_args[31:0], 32'h43424140);
        send(8'h10); send(8'h01);
        check("R12 idle after empty response", snap_cmd, 8'h10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_handshake;
        t_fixed_rsp;
        t_var_args;
        t_overflow;
        t_unknown;
        t_wrong_dir;
        t_zero_rsp;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule